// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block turns exception requests into the register-file and status-register updates that a processor core needs when it enters an exception handler or leaves one. Seven request lines can be raised: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. In any cycle at most one of them is accepted. The block then produces, in the following cycle, a set of write strobes with their data. These strobes save the current status word into the banked saved-status register of the target mode. They write a new current status word, store the return address in the target mode's banked link register, and load the program counter with the exception vector.

A return request asks for the opposite step. The block writes the saved status of the current mode back into the current status register and writes the current mode's link register into the program counter. The core supplies both values from its banked register file. A return is honoured only when no exception is accepted in the same cycle and the current mode has its own banked copies. All effects come out as single-cycle strobes registered on the clock, so the surrounding datapath only has to apply them.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every write strobe (`psr_we`, `save_we`, `link_we`, `pc_we`) is 0.
- R2: When several requests are raised together, exactly one is accepted. The order from highest to lowest priority is: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: A normal interrupt request is ignored while status bit 7 (I) is 1. A fast interrupt request is ignored while status bit 6 (F) is 1.
- R4: The cycle after a request is accepted, `save_we` is 1, `save_mode` is the target mode and `save_wdata` equals the status word that was current when the request was accepted.
- R5: In that same cycle, `psr_we` is 1 and `psr_wdata` keeps bits 31..8 of the old status word. It sets bit 7 (I) to 1. It sets bit 6 (F) to 1 for reset and fast interrupt and leaves it unchanged otherwise. It clears bit 5 (T) and puts the target mode in bits 4..0. Target modes: reset and software interrupt 5'b10011, undefined 5'b11011, both aborts 5'b10111, normal interrupt 5'b10010, fast interrupt 5'b10001.
- R6: In that same cycle, `link_we` is 1, `link_mode` is the target mode and `link_wdata` equals `ret_addr` as sampled when the request was accepted.
- R7: In that same cycle, `pc_we` is 1 and `pc_wdata` is `VEC_BASE` plus the offset of the exception: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R8: A return request with no accepted exception, in a mode other than 5'b10000 and 5'b11111, gives the next cycle `psr_we`=1 with `psr_wdata`=`psr_saved`, `pc_we`=1 with `pc_wdata`=`link_cur`, and `save_we`=`link_we`=0.
- R9: A return request in mode 5'b10000 or 5'b11111 is ignored, and so is one that arrives in a cycle where an exception is accepted. An ignored return gives no strobe of its own.
- R10: With no accepted request and no honoured return, all four strobes are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| ret_req | input | 1 | Return-from-exception request |
| psr_cur | input | 32 | Current status word |
| ret_addr | input | AW | Return address to save on entry |
| psr_saved | input | 32 | Saved status word of the current mode |
| link_cur | input | AW | Link register of the current mode |
| psr_we | output | 1 | Current status write strobe |
| psr_wdata | output | 32 | New current status word |
| save_we | output | 1 | Saved status write strobe |
| save_mode | output | 5 | Bank selected for the saved status write |
| save_wdata | output | 32 | Saved status word to write |
| link_we | output | 1 | Link register write strobe |
| link_mode | output | 5 | Bank selected for the link write |
| link_wdata | output | AW | Return address to write |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | AW | New program counter |

## Verification
The hardest situations to reach are those where masking and priority act together. One example is a fast interrupt that would win but is masked by F, so that a lower request such as a normal interrupt or a prefetch abort must win. Another is a return raised in the same cycle as an exception, or raised in a mode with no banked copies. The bench reaches all of these in one sweep. It covers every combination of the seven request lines, against every setting of I, F and T, four different current modes, and the return request both on and off. For each combination it works out the expected winner and strobes arithmetically.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NUM_SRC = 7;
  localparam int PSR_I   = 7;
  localparam int PSR_F   = 6;
  localparam int PSR_T   = 5;

  // source index equals priority rank (0 = highest)
  localparam int SRC_FIQ = 2;
  localparam int SRC_IRQ = 3;

  typedef enum logic [2:0] {
    EK_RESET = 3'd0,
    EK_DABT  = 3'd1,
    EK_FIQ   = 3'd2,
    EK_IRQ   = 3'd3,
    EK_PABT  = 3'd4,
    EK_UNDEF = 3'd5,
    EK_SWI   = 3'd6,
    EK_NONE  = 3'd7
  } exc_kind_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  function automatic logic [4:0] target_mode(exc_kind_e k);
    case (k)
      EK_RESET, EK_SWI: return MODE_SVC;
      EK_UNDEF:         return MODE_UND;
      EK_PABT, EK_DABT: return MODE_ABT;
      EK_IRQ:           return MODE_IRQ;
      EK_FIQ:           return MODE_FIQ;
      default:          return MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vec_offset(exc_kind_e k);
    case (k)
      EK_RESET: return 8'h00;
      EK_UNDEF: return 8'h04;
      EK_SWI:   return 8'h08;
      EK_PABT:  return 8'h0C;
      EK_DABT:  return 8'h10;
      EK_IRQ:   return 8'h18;
      EK_FIQ:   return 8'h1C;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] entry_psr(logic [31:0] old, exc_kind_e k);
    logic [31:0] r;
    r        = old;
    r[PSR_I] = 1'b1;
    if (k == EK_RESET || k == EK_FIQ) r[PSR_F] = 1'b1;
    r[PSR_T] = 1'b0;
    r[4:0]   = target_mode(k);
    return r;
  endfunction

  function automatic logic mode_is_banked(logic [4:0] m);
    return (m != MODE_USR) && (m != MODE_SYS);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         irq_masked,
  input  logic         fiq_masked,
  output logic [N-1:0] grant,
  output exc_kind_e    kind,
  output logic         any
);

  logic [N-1:0] live;

  always_comb begin
    live          = req;
    live[SRC_FIQ] = req[SRC_FIQ] & ~fiq_masked;
    live[SRC_IRQ] = req[SRC_IRQ] & ~irq_masked;
  end

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    kind  = EK_NONE;
    for (int i = 0; i < N; i++) begin
      if (live[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        kind     = exc_kind_e'(3'(i));
      end
    end
    any = found;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (req != '0 && grant != '0)));

  // R2
  grant_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> grant[0]);

  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked |-> !grant[SRC_IRQ]);

  // R3
  fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_masked |-> !grant[SRC_FIQ]);

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_seq_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  exc_kind_e      kind,
  input  logic [31:0]    psr_old,
  output logic [31:0]    psr_new,
  output logic [4:0]     tgt_mode,
  output logic [AW-1:0]  vector
);

  always_comb begin
    psr_new  = entry_psr(psr_old, kind);
    tgt_mode = target_mode(kind);
    vector   = VEC_BASE + AW'(vec_offset(kind));
  end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_reset,
  input  logic          req_undef,
  input  logic          req_swi,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic          ret_req,
  input  logic [31:0]   psr_cur,
  input  logic [AW-1:0] ret_addr,
  input  logic [31:0]   psr_saved,
  input  logic [AW-1:0] link_cur,
  output logic          psr_we,
  output logic [31:0]   psr_wdata,
  output logic          save_we,
  output logic [4:0]    save_mode,
  output logic [31:0]   save_wdata,
  output logic          link_we,
  output logic [4:0]    link_mode,
  output logic [AW-1:0] link_wdata,
  output logic          pc_we,
  output logic [AW-1:0] pc_wdata
);

  localparam int NREQ = NUM_SRC;

  logic [NREQ-1:0] req_vec;
  logic [NREQ-1:0] grant;
  exc_kind_e       win_kind;
  logic            win_any;
  logic [31:0]     entry_psr_w;
  logic [4:0]      entry_mode_w;
  logic [AW-1:0]   entry_vec_w;
  logic            ret_ok;

  // bit position = priority rank
  assign req_vec = {req_swi, req_undef, req_pabt, req_irq, req_fiq, req_dabt, req_reset};

  exc_arbiter #(.N(NREQ)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_vec),
    .irq_masked (psr_cur[PSR_I]),
    .fiq_masked (psr_cur[PSR_F]),
    .grant      (grant),
    .kind       (win_kind),
    .any        (win_any)
  );

  exc_entry_calc #(.AW(AW), .VEC_BASE(VEC_BASE)) u_calc (
    .kind     (win_kind),
    .psr_old  (psr_cur),
    .psr_new  (entry_psr_w),
    .tgt_mode (entry_mode_w),
    .vector   (entry_vec_w)
  );

  assign ret_ok = ret_req && !win_any && mode_is_banked(psr_cur[4:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr_we     <= 1'b0;
      psr_wdata  <= '0;
      save_we    <= 1'b0;
      save_mode  <= '0;
      save_wdata <= '0;
      link_we    <= 1'b0;
      link_mode  <= '0;
      link_wdata <= '0;
      pc_we      <= 1'b0;
      pc_wdata   <= '0;
    end else begin
      psr_we  <= 1'b0;
      save_we <= 1'b0;
      link_we <= 1'b0;
      pc_we   <= 1'b0;
      if (win_any) begin
        psr_we     <= 1'b1;
        psr_wdata  <= entry_psr_w;
        save_we    <= 1'b1;
        save_mode  <= entry_mode_w;
        save_wdata <= psr_cur;
        link_we    <= 1'b1;
        link_mode  <= entry_mode_w;
        link_wdata <= ret_addr;
        pc_we      <= 1'b1;
        pc_wdata   <= entry_vec_w;
      end else if (ret_ok) begin
        psr_we    <= 1'b1;
        psr_wdata <= psr_saved;
        pc_we     <= 1'b1;
        pc_wdata  <= link_cur;
      end
    end
  end

  // R4
  save_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_we |-> save_wdata == $past(psr_cur));

  // R5
  entry_psr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_we |-> psr_we && psr_wdata[PSR_I] && !psr_wdata[PSR_T] &&
                psr_wdata[4:0] == save_mode && psr_wdata[31:8] == $past(psr_cur[31:8]));

  // R6
  entry_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_we |-> link_we && pc_we && link_mode == save_mode && link_wdata == $past(ret_addr));

  // R8
  return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && !save_we) |-> pc_we && !link_we &&
      psr_wdata == $past(psr_saved) && pc_wdata == $past(link_cur));

  // R9
  return_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !mode_is_banked(psr_cur[4:0]) && req_vec == '0) |=> !psr_we && !pc_we);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_req && req_vec == '0) |=> !psr_we && !save_we && !link_we && !pc_we);

endmodule

// File: tb/test_exc_seq.sv
`timescale 1ns/1ps
module test_exc_seq;

  localparam int AW = 32;
  localparam logic [31:0] VBASE = 32'hFFFF_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
  logic req_dabt = 0, req_irq = 0, req_fiq = 0, ret_req = 0;
  logic [31:0] psr_cur = '0, ret_addr = '0, psr_saved = '0, link_cur = '0;
  logic psr_we, save_we, link_we, pc_we;
  logic [31:0] psr_wdata, save_wdata, link_wdata, pc_wdata;
  logic [4:0] save_mode, link_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_seq #(.AW(AW), .VEC_BASE(VBASE)) i_exc_seq (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq),
    .req_fiq(req_fiq), .ret_req(ret_req),
    .psr_cur(psr_cur), .ret_addr(ret_addr), .psr_saved(psr_saved), .link_cur(link_cur),
    .psr_we(psr_we), .psr_wdata(psr_wdata), .save_we(save_we), .save_mode(save_mode),
    .save_wdata(save_wdata), .link_we(link_we), .link_mode(link_mode),
    .link_wdata(link_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] mode_of(int idx);
    case (idx)
      0: return 5'b10000;
      1: return 5'b10011;
      2: return 5'b11111;
      default: return 5'b10010;
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: requests raised while in reset must give nothing
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq, ret_req} = '1;
    psr_cur = 32'h0000_0013;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "strobes in reset", {28'd0, psr_we, save_we, link_we, pc_we}, 32'd0);
    @(negedge clk);
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq, ret_req} = '0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "strobes after reset", {28'd0, psr_we, save_we, link_we, pc_we}, 32'd0);

    for (int rq = 0; rq < 128; rq++) begin
      for (int st = 0; st < 32; st++) begin
        for (int rt = 0; rt < 2; rt++) begin
          logic [6:0] r;
          logic       ib, fb, tb;
          logic [4:0] md, tmode;
          logic [31:0] psr, exp_psr, vec;
          int win, nreq;
          logic banked;
          string ptag;
          r  = 7'(rq);
          ib = st[0]; fb = st[1]; tb = st[2];
          md = mode_of(st >> 3);
          psr = {4'(rq) ^ 4'hA, 12'h5C3, 4'(st), 4'h9, ib, fb, tb, md};

          // r: [0]reset [1]undef [2]swi [3]pabt [4]dabt [5]irq [6]fiq
          if (r[0])              win = 0;
          else if (r[4])         win = 4;
          else if (r[6] && !fb)  win = 6;
          else if (r[5] && !ib)  win = 5;
          else if (r[3])         win = 3;
          else if (r[1])         win = 1;
          else if (r[2])         win = 2;
          else                   win = -1;
          nreq = $countones(r);

          case (win)
            0: begin tmode = 5'b10011; vec = VBASE + 32'h00; end
            1: begin tmode = 5'b11011; vec = VBASE + 32'h04; end
            2: begin tmode = 5'b10011; vec = VBASE + 32'h08; end
            3: begin tmode = 5'b10111; vec = VBASE + 32'h0C; end
            4: begin tmode = 5'b10111; vec = VBASE + 32'h10; end
            5: begin tmode = 5'b10010; vec = VBASE + 32'h18; end
            default: begin tmode = 5'b10001; vec = VBASE + 32'h1C; end
          endcase
          exp_psr = {psr[31:8], 1'b1, (fb | win == 0 | win == 6), 1'b0, tmode};
          banked = (md != 5'b10000) && (md != 5'b11111);

          @(negedge clk);
          {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_undef, req_reset} = r;
          ret_req   = rt[0];
          psr_cur   = psr;
          ret_addr  = 32'h0010_0000 + 32'(rq * 256 + st * 4);
          psr_saved = ~psr;
          link_cur  = 32'h8000_0000 | 32'(rq * 64 + st);
          @(posedge clk); #1;

          if (win >= 0) begin
            ptag = (nreq > 1) ? "R2" : "R7";
            chk(ptag, "pc_wdata vector", pc_wdata, vec);
            chk("R4", "save_we", 32'(save_we), 32'd1);
            chk("R4", "save_mode", 32'(save_mode), 32'(tmode));
            chk("R4", "save_wdata", save_wdata, psr);
            chk("R5", "psr_we", 32'(psr_we), 32'd1);
            chk("R5", "psr_wdata", psr_wdata, exp_psr);
            chk("R6", "link_we/mode", {26'd0, link_we, link_mode}, {26'd0, 1'b1, tmode});
            chk("R6", "link_wdata", link_wdata, ret_addr);
            chk("R7", "pc_we", 32'(pc_we), 32'd1);
          end else if (rt[0] && banked) begin
            chk("R8", "strobes", {28'd0, psr_we, save_we, link_we, pc_we}, 32'b1001);
            chk("R8", "psr_wdata", psr_wdata, psr_saved);
            chk("R8", "pc_wdata", pc_wdata, link_cur);
          end else if (rt[0]) begin
            chk("R9", "strobes", {28'd0, psr_we, save_we, link_we, pc_we}, 32'd0);
          end else if (nreq != 0) begin
            chk("R3", "masked request strobes", {28'd0, psr_we, save_we, link_we, pc_we}, 32'd0);
          end else begin
            chk("R10", "idle strobes", {28'd0, psr_we, save_we, link_we, pc_we}, 32'd0);
          end
        end
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule